// File: doc/BRIEF.md
# Windowed Pixel Write Engine

This block accepts a stream of 16-bit pixel words on a data port and places them into a rectangular region of a byte-addressed frame buffer. Software first writes the window corners, the bytes-per-pixel value, a rotation field and a source code through a single select/data write port. When a source code is written, or when a data word arrives with no transfer pending, the block validates the settings and works out how many words the window needs. The incoming words go into an internal staging memory. Nothing reaches the frame buffer until the last expected word arrives. After that word, the staged window is copied out one byte per cycle, using the panel width as the line stride.

The engine also keeps a dirty rectangle, which the display refresh logic reads. Each committed window is merged into this rectangle, and the refresh side empties it with a clear strobe. A busy flag shows when a transfer is pending or being copied. A one-cycle done pulse marks the end of each transfer.

Top module: `wpe_top`

## Requirements
- R1: Setup fails, and no transfer is armed, if any of these holds: the source code is above 3, bytes-per-pixel is 0, X end is below X start, Y end is below Y start, or the word count is 0 or larger than the staging depth. A data word that arrives while no transfer is pending and setup fails is discarded, and busy stays low.
- R2: The word count is bytes-per-pixel times width times height, divided by 2 and rounded down. Width is X end minus X start plus 1, and height is Y end minus Y start plus 1. Busy stays high until exactly that many words have been taken.
- R3: The write port select codes are: 0 X start, 1 X end, 2 Y start, 3 Y end, 4 bytes-per-pixel (low 3 bits), 5 rotation (low 2 bits), 6 source (low 3 bits), 7 data. A data word that arrives when no transfer is pending runs setup. On success that word becomes word 0 of the transfer, and busy is high from the next cycle.
- R4: A source write stores the low 3 bits of the value and runs setup again using the new code. On success the block arms a fresh transfer with zero words received, even if another transfer was partly received. On failure any pending transfer continues unchanged.
- R5: On commit, stream byte k (the low byte of each word comes first) is written to address bpp*(W*(Ys+r)+Xs)+c. Here r = k div (bpp*width), c = k mod (bpp*width), and W is the panel width. Exactly 2*count bytes are written, so when the window has an odd byte total its final byte is not written.
- R6: In the cycle done is seen, the dirty box already includes the committed window. The minimums become the smaller of the current value and the window start. The exclusive maximums become the larger of the current value and the window end plus 1.
- R7: Reset or a clear strobe empties the dirty box: min X is set to the panel width, max X to 0, min Y to the panel height, and max Y to 0.
- R8: If a clear strobe and a commit update fall in the same cycle, the result is the empty box merged with the window, so the box equals the window.
- R9: A nonzero rotation field latched at setup still counts the words and still pulses done. It writes nothing to the frame buffer and leaves the dirty box unchanged.
- R10: Done is high for exactly one cycle per transfer, and busy is low in that cycle.
- R11: Data words that arrive while the copy is running are discarded and do not arm a new transfer.
- R12: The window geometry is captured at setup. Register writes made while words are still arriving do not change where the current window lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the select/data port |
| wr_sel | input | 3 | Target select (see R3) |
| wr_data | input | 16 | Write value or pixel word |
| pan_w | input | CW+1 | Panel width in pixels (line stride) |
| pan_h | input | CW+1 | Panel height in lines |
| dirty_clr | input | 1 | Refresh has consumed the dirty box |
| busy | output | 1 | Transfer pending or being copied |
| done | output | 1 | One-cycle end-of-transfer pulse |
| fb_we | output | 1 | Frame-buffer byte write enable |
| fb_addr | output | FBAW | Frame-buffer byte address |
| fb_data | output | 8 | Frame-buffer byte data |
| dirty_x0 | output | CW+1 | Dirty box minimum X |
| dirty_y0 | output | CW+1 | Dirty box minimum Y |
| dirty_x1 | output | CW+1 | Dirty box exclusive maximum X |
| dirty_y1 | output | CW+1 | Dirty box exclusive maximum Y |

## Verification
The clear strobe from the refresh side and the dirty-box merge at the end of a copy can land in the same cycle. If clear wins, the new window is lost. If the merge wins, a stale box survives. The bench counts cycles from the final data word so that the strobe is high exactly in the cycle the merge happens. It then expects the box to equal that window alone. A second run drives the strobe by itself and expects the empty box.

// File: rtl/wpe_pkg.sv
package wpe_pkg;
  typedef enum logic [2:0] {
    SEL_XS   = 3'd0,
    SEL_XE   = 3'd1,
    SEL_YS   = 3'd2,
    SEL_YE   = 3'd3,
    SEL_BPP  = 3'd4,
    SEL_ROT  = 3'd5,
    SEL_SRC  = 3'd6,
    SEL_DATA = 3'd7
  } wpe_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_COPY = 2'd2
  } wpe_state_e;

  localparam logic [2:0] SRC_LIMIT = 3'd3;
endpackage

// File: rtl/wpe_setup.sv
module wpe_setup #(
  parameter int CW    = 10,
  parameter int DEPTH = 256,
  parameter int FBAW  = 24,
  parameter int WCW   = 9
) (
  input  logic [CW-1:0]   xs,
  input  logic [CW-1:0]   xe,
  input  logic [CW-1:0]   ys,
  input  logic [CW-1:0]   ye,
  input  logic [2:0]      bpp,
  input  logic [2:0]      src,
  input  logic [CW:0]     pan_w,
  output logic            ok,
  output logic [WCW-1:0]  words,
  output logic [FBAW-1:0] base,
  output logic [FBAW-1:0] stride,
  output logic [FBAW-1:0] rowb
);
  import wpe_pkg::*;
  localparam int DIM = CW + 1;
  localparam int PRW = 3 + 2 * DIM;

  logic [DIM-1:0] dx, dy;
  logic [PRW-1:0] prod, half;

  always_comb begin
    dx   = DIM'(xe) - DIM'(xs) + DIM'(1);
    dy   = DIM'(ye) - DIM'(ys) + DIM'(1);
    prod = PRW'(bpp) * PRW'(dx) * PRW'(dy);
    half = prod >> 1;
    ok   = (src <= SRC_LIMIT) && (bpp != 3'd0) && (xe >= xs) && (ye >= ys) &&
           (half != '0) && (half <= PRW'(DEPTH));
    words  = half[WCW-1:0];
    base   = FBAW'(bpp) * (FBAW'(pan_w) * FBAW'(ys) + FBAW'(xs));
    stride = FBAW'(bpp) * FBAW'(pan_w);
    rowb   = FBAW'(bpp) * FBAW'(dx);
  end
endmodule

// File: rtl/wpe_stage.sv
module wpe_stage #(
  parameter int DEPTH = 256,
  parameter int SAW   = 8
) (
  input  logic           clk,
  input  logic           we,
  input  logic [SAW-1:0] waddr,
  input  logic [15:0]    wdata,
  input  logic [SAW-1:0] raddr,
  output logic [15:0]    rdata
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wpe_copy.sv
module wpe_copy #(
  parameter int FBAW = 24,
  parameter int SAW  = 8,
  parameter int NBW  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [FBAW-1:0] base_i,
  input  logic [FBAW-1:0] stride_i,
  input  logic [FBAW-1:0] rowb_i,
  input  logic [NBW-1:0]  nbytes_i,
  output logic [SAW-1:0]  raddr,
  input  logic [15:0]     rdata,
  output logic            fb_we,
  output logic [FBAW-1:0] fb_addr,
  output logic [7:0]      fb_data,
  output logic            fin,
  output logic            commit
);
  logic            run, v1, s1, l1;
  logic [NBW-1:0]  k, nb_q;
  logic [FBAW-1:0] col, rowa, stride_q, rowb_q, a1;

  assign raddr  = k[SAW:1];
  assign commit = v1 && l1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; k <= '0; nb_q <= '0; col <= '0; rowa <= '0;
      stride_q <= '0; rowb_q <= '0;
      v1 <= 1'b0; a1 <= '0; s1 <= 1'b0; l1 <= 1'b0;
      fb_we <= 1'b0; fb_addr <= '0; fb_data <= '0; fin <= 1'b0;
    end else begin
      v1 <= run;
      a1 <= rowa + col;
      s1 <= k[0];
      l1 <= (k == nb_q - NBW'(1));
      if (start) begin
        run      <= 1'b1;
        k        <= '0;
        col      <= '0;
        rowa     <= base_i;
        stride_q <= stride_i;
        rowb_q   <= rowb_i;
        nb_q     <= nbytes_i;
      end else if (run) begin
        k <= k + NBW'(1);
        if (col == rowb_q - FBAW'(1)) begin
          col  <= '0;
          rowa <= rowa + stride_q;
        end else begin
          col <= col + FBAW'(1);
        end
        if (k == nb_q - NBW'(1)) run <= 1'b0;
      end
      fb_we   <= v1;
      fb_addr <= a1;
      fb_data <= s1 ? rdata[15:8] : rdata[7:0];
      fin     <= v1 && l1;
    end
  end

  AST_COPY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (k < nb_q)); // R5
endmodule

// File: rtl/wpe_dirty.sv
module wpe_dirty #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW:0]   pan_w,
  input  logic [CW:0]   pan_h,
  input  logic          clr,
  input  logic          upd,
  input  logic [CW-1:0] wx0,
  input  logic [CW-1:0] wy0,
  input  logic [CW:0]   wx1,
  input  logic [CW:0]   wy1,
  output logic [CW:0]   x0,
  output logic [CW:0]   y0,
  output logic [CW:0]   x1,
  output logic [CW:0]   y1
);
  localparam int DIM = CW + 1;
  logic [DIM-1:0] bx0, by0, bx1, by1, nx0, ny0, nx1, ny1;

  always_comb begin
    bx0 = clr ? pan_w : x0;
    by0 = clr ? pan_h : y0;
    bx1 = clr ? '0 : x1;
    by1 = clr ? '0 : y1;
    nx0 = bx0; ny0 = by0; nx1 = bx1; ny1 = by1;
    if (upd) begin
      if (DIM'(wx0) < bx0) nx0 = DIM'(wx0);
      if (DIM'(wy0) < by0) ny0 = DIM'(wy0);
      if (wx1 > bx1)       nx1 = wx1;
      if (wy1 > by1)       ny1 = wy1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x0 <= pan_w; y0 <= pan_h; x1 <= '0; y1 <= '0;
    end else begin
      x0 <= nx0; y0 <= ny0; x1 <= nx1; y1 <= ny1;
    end
  end

  AST_EMPTY_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr && !upd) |=> (x1 == '0 && y1 == '0)); // R7
  AST_UNION_COVERS: assert property (@(posedge clk) disable iff (rst)
    upd |=> (x0 <= DIM'($past(wx0)) && x1 >= $past(wx1) &&
             y0 <= DIM'($past(wy0)) && y1 >= $past(wy1))); // R6
endmodule

// File: rtl/wpe_top.sv
module wpe_top #(
  parameter int CW    = 10,
  parameter int DEPTH = 256,
  parameter int FBAW  = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [15:0]     wr_data,
  input  logic [CW:0]     pan_w,
  input  logic [CW:0]     pan_h,
  input  logic            dirty_clr,
  output logic            busy,
  output logic            done,
  output logic            fb_we,
  output logic [FBAW-1:0] fb_addr,
  output logic [7:0]      fb_data,
  output logic [CW:0]     dirty_x0,
  output logic [CW:0]     dirty_y0,
  output logic [CW:0]     dirty_x1,
  output logic [CW:0]     dirty_y1
);
  import wpe_pkg::*;
  localparam int DIM = CW + 1;
  localparam int SAW = $clog2(DEPTH);
  localparam int WCW = SAW + 1;
  localparam int NBW = SAW + 2;

  logic [CW-1:0]   xs_q, xe_q, ys_q, ye_q, g_xs, g_ys;
  logic [2:0]      bpp_q, src_q, src_eff;
  logic [1:0]      rot_q, g_rot, rot_now;
  wpe_state_e      st_q;
  logic [WCW-1:0]  widx_q, g_words, idx_now, words_now, su_words;
  logic [DIM-1:0]  g_xe1, g_ye1;
  logic [FBAW-1:0] g_base, g_stride, g_rowb, su_base, su_stride, su_rowb;
  logic [FBAW-1:0] cp_base, cp_stride, cp_rowb;
  logic            rot_done_q, su_ok, src_wr, dat_wr, idle, arm_src, take;
  logic            last_word, cp_start, cp_fin, cp_commit;
  logic [SAW-1:0]  rd_addr;
  logic [15:0]     rd_data;

  always_comb begin
    src_wr    = wr_en && (wr_sel == SEL_SRC);
    dat_wr    = wr_en && (wr_sel == SEL_DATA);
    src_eff   = src_wr ? wr_data[2:0] : src_q;
    idle      = (st_q == ST_IDLE);
    arm_src   = src_wr && (st_q != ST_COPY) && su_ok;
    take      = dat_wr && ((st_q == ST_RECV) || (idle && su_ok));
    idx_now   = idle ? '0 : widx_q;
    words_now = idle ? su_words : g_words;
    rot_now   = idle ? rot_q : g_rot;
    last_word = take && (idx_now + WCW'(1) == words_now);
    cp_start  = last_word && (rot_now == 2'd0);
    cp_base   = idle ? su_base : g_base;
    cp_stride = idle ? su_stride : g_stride;
    cp_rowb   = idle ? su_rowb : g_rowb;
  end

  wpe_setup #(.CW(CW), .DEPTH(DEPTH), .FBAW(FBAW), .WCW(WCW)) u_setup (
    .xs(xs_q), .xe(xe_q), .ys(ys_q), .ye(ye_q), .bpp(bpp_q), .src(src_eff),
    .pan_w(pan_w), .ok(su_ok), .words(su_words), .base(su_base),
    .stride(su_stride), .rowb(su_rowb));

  wpe_stage #(.DEPTH(DEPTH), .SAW(SAW)) u_stage (
    .clk(clk), .we(take), .waddr(idx_now[SAW-1:0]), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data));

  wpe_copy #(.FBAW(FBAW), .SAW(SAW), .NBW(NBW)) u_copy (
    .clk(clk), .rst(rst), .start(cp_start), .base_i(cp_base),
    .stride_i(cp_stride), .rowb_i(cp_rowb), .nbytes_i({words_now, 1'b0}),
    .raddr(rd_addr), .rdata(rd_data), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_data(fb_data), .fin(cp_fin), .commit(cp_commit));

  wpe_dirty #(.CW(CW)) u_dirty (
    .clk(clk), .rst(rst), .pan_w(pan_w), .pan_h(pan_h), .clr(dirty_clr),
    .upd(cp_commit), .wx0(g_xs), .wy0(g_ys), .wx1(g_xe1), .wy1(g_ye1),
    .x0(dirty_x0), .y0(dirty_y0), .x1(dirty_x1), .y1(dirty_y1));

  always_ff @(posedge clk) begin
    if (rst) begin
      xs_q <= '0; xe_q <= '0; ys_q <= '0; ye_q <= '0;
      bpp_q <= 3'd2; src_q <= '0; rot_q <= '0;
      st_q <= ST_IDLE; widx_q <= '0; rot_done_q <= 1'b0;
      g_xs <= '0; g_ys <= '0; g_xe1 <= '0; g_ye1 <= '0; g_rot <= '0;
      g_words <= '0; g_base <= '0; g_stride <= '0; g_rowb <= '0;
    end else begin
      rot_done_q <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          SEL_XS:  xs_q  <= wr_data[CW-1:0];
          SEL_XE:  xe_q  <= wr_data[CW-1:0];
          SEL_YS:  ys_q  <= wr_data[CW-1:0];
          SEL_YE:  ye_q  <= wr_data[CW-1:0];
          SEL_BPP: bpp_q <= wr_data[2:0];
          SEL_ROT: rot_q <= wr_data[1:0];
          SEL_SRC: src_q <= wr_data[2:0];
          default: ;
        endcase
      end
      if (arm_src || (take && idle)) begin
        g_xs <= xs_q; g_ys <= ys_q;
        g_xe1 <= DIM'(xe_q) + DIM'(1);
        g_ye1 <= DIM'(ye_q) + DIM'(1);
        g_rot <= rot_q; g_words <= su_words;
        g_base <= su_base; g_stride <= su_stride; g_rowb <= su_rowb;
      end
      if (arm_src) begin
        st_q   <= ST_RECV;
        widx_q <= '0;
      end else if (take) begin
        if (last_word) begin
          st_q       <= (rot_now == 2'd0) ? ST_COPY : ST_IDLE;
          rot_done_q <= (rot_now != 2'd0);
          widx_q     <= '0;
        end else begin
          st_q   <= ST_RECV;
          widx_q <= idx_now + WCW'(1);
        end
      end else if (st_q == ST_COPY && cp_commit) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = cp_fin | rot_done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_IDLE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_ROT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && g_rot != 2'd0) |-> !fb_we); // R9
  AST_SETUP_GATE: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && idle && !su_ok) |=> (st_q == ST_IDLE)); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RECV) |-> (widx_q < g_words)); // R2
endmodule

// File: tb/tb_wpe_top.sv
module tb_wpe_top;
  import wpe_pkg::*;
  localparam int CLK_P = 10;
  localparam int W = 64;
  localparam int H = 48;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, dirty_clr = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic busy, done, fb_we;
  logic [23:0] fb_addr;
  logic [7:0] fb_data;
  logic [10:0] dx0, dy0, dx1, dy1;
  int n_chk = 0, n_bad = 0;
  int qa[$];
  int qd[$];
  int bx0, bx1, by0, by1;

  always #(CLK_P/2) clk = ~clk;

  wpe_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pan_w(11'(W)), .pan_h(11'(H)), .dirty_clr(dirty_clr), .busy(busy),
    .done(done), .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
    .dirty_x0(dx0), .dirty_y0(dy0), .dirty_x1(dx1), .dirty_y1(dy1));

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // monitor: pops scoreboard on each frame-buffer byte write
  always @(negedge clk) begin
    if (!rst && fb_we) begin
      if (qa.size() == 0) begin
        chk("R5/R9 unexpected frame-buffer write", 1, 0);
      end else begin
        chk("R5 address", int'(fb_addr), qa.pop_front());
        chk("R5 byte", int'(fb_data), qd.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] s, input int d);
    wr_en = 1'b1; wr_sel = s; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setwin(int bpp, int xs, int xe, int ys, int ye, int rot);
    wr(SEL_BPP, bpp); wr(SEL_XS, xs); wr(SEL_XE, xe);
    wr(SEL_YS, ys); wr(SEL_YE, ye); wr(SEL_ROT, rot);
  endtask

  function automatic int nwords(int bpp, int xs, int xe, int ys, int ye);
    return bpp * (xe - xs + 1) * (ye - ys + 1) / 2;
  endfunction

  task automatic push_exp(int bpp, int xs, int xe, int ys, int ye, int seed);
    int rb = bpp * (xe - xs + 1);
    for (int k = 0; k < 2 * nwords(bpp, xs, xe, ys, ye); k++) begin
      int w = (seed + (k >> 1)) & 'hffff;
      qd.push_back((k % 2) ? (w >> 8) : (w & 255));
      qa.push_back(bpp * (W * (ys + k / rb) + xs) + k % rb);
    end
  endtask

  task automatic send(int seed, int from, int to);
    for (int i = from; i < to; i++) wr(SEL_DATA, (seed + i) & 'hffff);
  endtask

  task automatic grow(int xs, int xe, int ys, int ye);
    if (xs < bx0) bx0 = xs;
    if (ys < by0) by0 = ys;
    if (xe + 1 > bx1) bx1 = xe + 1;
    if (ye + 1 > by1) by1 = ye + 1;
  endtask

  task automatic chk_box(string tag);
    chk({tag, " min x"}, int'(dx0), bx0);
    chk({tag, " min y"}, int'(dy0), by0);
    chk({tag, " max x"}, int'(dx1), bx1);
    chk({tag, " max y"}, int'(dy1), by1);
  endtask

  task automatic wait_done(string tag);
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
    chk({tag, " done seen"}, int'(done), 1);
    chk("R10 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R10 done lasts one cycle", int'(done), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bx0 = W; bx1 = 0; by0 = H; by1 = 0;
    // R7 reset state
    chk("R7 busy after reset", int'(busy), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R7 no write after reset", int'(fb_we), 0);
    chk_box("R7 reset box");

    // R2 R3 R5 R6: 2 bytes/pixel, 4x3 window, 12 words
    setwin(2, 3, 6, 2, 4, 0);
    push_exp(2, 3, 6, 2, 4, 'h1200);
    send('h1200, 0, 1);
    chk("R3 busy after first word", int'(busy), 1);
    send('h1200, 1, 11);
    chk("R2 busy before final word", int'(busy), 1);
    send('h1200, 11, 12);
    wait_done("R2");
    grow(3, 6, 2, 4);
    chk_box("R6 first window");

    // R5 odd byte total: 3 bytes/pixel, 3x1 -> 4 words, 8 bytes
    setwin(3, 10, 12, 5, 5, 0);
    push_exp(3, 10, 12, 5, 5, 'h3400);
    send('h3400, 0, 4);
    wait_done("R5");
    chk("R5 all expected bytes written", qa.size(), 0);
    grow(10, 12, 5, 5);
    chk_box("R6 union");

    // R1 failing setups
    setwin(2, 8, 7, 0, 0, 0);
    wr(SEL_DATA, 1); @(negedge clk);
    chk("R1 x end below start", int'(busy), 0);
    setwin(0, 0, 1, 0, 0, 0);
    wr(SEL_DATA, 1); @(negedge clk);
    chk("R1 zero bytes per pixel", int'(busy), 0);
    setwin(4, 0, 19, 0, 19, 0);
    wr(SEL_DATA, 1); @(negedge clk);
    chk("R1 oversize window", int'(busy), 0);
    setwin(2, 0, 1, 0, 0, 0);
    wr(SEL_SRC, 4);
    chk("R1 source above 3", int'(busy), 0);
    wr(SEL_DATA, 1); @(negedge clk);
    chk("R1 data with bad source", int'(busy), 0);

    // R4 source write arms, restarts, and a failing one keeps the pending transfer
    wr(SEL_SRC, 0);
    chk("R4 source write arms", int'(busy), 1);
    wr(SEL_DATA, 'h7777);
    wr(SEL_SRC, 0);
    chk("R4 restart keeps busy", int'(busy), 1);
    push_exp(2, 0, 1, 0, 0, 'h5600);
    send('h5600, 0, 1);
    wr(SEL_SRC, 5);
    chk("R4 failed source leaves transfer", int'(busy), 1);
    send('h5600, 1, 2);
    wait_done("R4");
    grow(0, 1, 0, 0);
    chk_box("R4 box");
    wr(SEL_XE, 0); wr(SEL_XS, 1); wr(SEL_SRC, 0);
    chk("R1 source reset with bad window", int'(busy), 0);

    // R12 geometry latched at setup
    setwin(2, 20, 21, 10, 11, 0);
    push_exp(2, 20, 21, 10, 11, 'h9a00);
    send('h9a00, 0, 1);
    wr(SEL_XS, 30); wr(SEL_YS, 1);
    send('h9a00, 1, 4);
    wait_done("R12");
    grow(20, 21, 10, 11);
    chk_box("R12 box");

    // R9 rotated path: counted, no writes, box unchanged
    setwin(2, 0, 3, 0, 0, 1);
    send('hbc00, 0, 3);
    chk("R9 rotated transfer counts", int'(busy), 1);
    send('hbc00, 3, 4);
    wait_done("R9");
    chk_box("R9 box unchanged");
    chk("R9 no pending writes", qa.size(), 0);

    // R11 data during copy is dropped
    setwin(2, 0, 7, 0, 3, 0);
    push_exp(2, 0, 7, 0, 3, 'hd000);
    send('hd000, 0, 32);
    wr(SEL_DATA, 'h4444);
    wait_done("R11");
    chk("R11 no transfer armed after copy", int'(busy), 0);
    grow(0, 7, 0, 3);
    chk_box("R11 box");

    // R8 clear coincides with commit: box equals window
    setwin(2, 40, 41, 30, 30, 0);
    push_exp(2, 40, 41, 30, 30, 'he100);
    send('he100, 0, 2);
    repeat (4) @(negedge clk);
    dirty_clr = 1'b1;
    @(negedge clk);
    dirty_clr = 1'b0;
    wait_done("R8");
    bx0 = 40; bx1 = 42; by0 = 30; by1 = 31;
    chk_box("R8 clear with commit");

    // R7 clear alone
    dirty_clr = 1'b1;
    @(negedge clk);
    dirty_clr = 1'b0;
    bx0 = W; bx1 = 0; by0 = H; by1 = 0;
    chk_box("R7 clear");
    chk("R5 scoreboard drained", qa.size(), 0);
    summary();
  end
endmodule